// File: doc/BRIEF.md
# Interrupt Pending and Trigger Tracker

This block keeps the per-source state of an interrupt distributor. Each source has an input level, a trigger mode, a handling model, an enable bit and a pending bit. Sources 0 to 31 are private: each CPU has its own copy of their level, enable and pending bits. Sources from 32 upward are shared: their level and enable are common to all CPUs, and their pending bit is kept per CPU. The block captures level-sensitive and edge-sensitive interrupts from the input lines and applies byte-wide software writes to enable, pending and configuration. It also accepts a software-generated interrupt command with a target filter, and a clear strobe from the acknowledge logic.

Its registered outputs are a pending vector and an enable vector for each CPU, which feed a separate priority arbiter. It also outputs the per-source trigger and model bits. Every update takes effect on the rising clock edge. The input lines must already be synchronised to the clock.

Top module: `irq_pend_tracker`

## Requirements
- R1: During and right after a synchronous reset, all pending bits are 0. Enable is 1 on every CPU for IDs 0–15 and 0 for every other ID. The trigger bit is 1 (edge) for IDs below 32 and 0 (level) for shared IDs. Every model bit is 0.
- R2: When an input goes from a stored low to high, pending is set if the source is edge-triggered, or if it is level-triggered and enabled. For a private line, pending is set for that line's CPU. For a shared line, it is set for the CPUs in that source's target mask.
- R3: An input that stays at its stored level, or that falls, changes no pending bit. A falling input only updates the stored level.
- R4: A set-enable write to a level-triggered source whose stored level is high also sets pending. For a private ID this is the requesting CPU; for a shared ID it is the target mask.
- R5: A configuration write (kind 4) to group g covers IDs 4g..4g+3. Bit 2k is the model of ID 4g+k (1 = clear on acknowledge for all CPUs). Bit 2k+1 is its trigger (1 = edge). For groups covering IDs below 32, 0xAA is ORed into the data, which forces edge mode.
- R6: For byte groups 0 and 1 (IDs 0–15), set-enable data is forced to 0xFF. Clear-enable, set-pending and clear-pending data are forced to 0x00.
- R7: Write kinds are 0 set-enable, 1 clear-enable, 2 set-pending, 3 clear-pending. Byte group g covers IDs 8g+b, where b is the data bit. Enable writes to private IDs act only on the requesting CPU's bank. Enable writes to shared IDs act on all CPUs. Kinds 5 to 7 do nothing.
- R8: Set-pending sets private IDs for the requesting CPU and shared IDs for their target mask. Clear-pending clears the ID on every CPU.
- R9: The software-interrupt command carries the ID in bits [9:0] and the filter in bits [25:24]. Filter 0 targets the CPU list in bits 16 and up. Filter 1 targets all CPUs but the requester. Filter 2 targets the requester only. Filter 3 targets all CPUs. IDs at or above the source count are ignored.
- R10: An acknowledge clear strobe clears the ID's pending bit on all CPUs when its model bit is 1, and on the acknowledging CPU only when the model bit is 0.
- R11: When a set and a clear of the same pending bit fall in the same cycle, the bit ends up set.
- R12: Shared line n is ID n+32. Private line k of CPU c (input bit 32c+k) is ID k in bank c. Pending and enable of ID i for CPU c appear on output bit c*NIRQ+i. The target mask for shared line n is bits n*NCPU..n*NCPU+NCPU-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shr_lvl_i | input | NSHARED | Shared interrupt lines |
| prv_lvl_i | input | NCPU*32 | Private lines, 32 per CPU |
| tgt_mask_i | input | NSHARED*NCPU | CPU target mask per shared source |
| wr_en_i | input | 1 | Register write strobe |
| wr_kind_i | input | 3 | Write kind (0..4 used) |
| wr_cpu_i | input | CW | Requesting CPU of the write |
| wr_grp_i | input | GW | Byte group or configuration group |
| wr_data_i | input | 8 | Write data |
| sgi_wr_i | input | 1 | Software-interrupt command strobe |
| sgi_cpu_i | input | CW | Requesting CPU of the command |
| sgi_cmd_i | input | 32 | Command word |
| ack_clr_i | input | 1 | Acknowledge clear strobe |
| ack_cpu_i | input | CW | Acknowledging CPU |
| ack_id_i | input | IDW | Acknowledged ID |
| pend_o | output | NCPU*NIRQ | Pending bits per CPU |
| en_o | output | NCPU*NIRQ | Enable bits per CPU |
| edge_o | output | NIRQ | Trigger mode per ID |
| model_o | output | NIRQ | Handling model per ID |

## Verification
Several pending operations can land on the same bit in one cycle. The most delicate pair is a set source, such as an input rising edge or a software command, together with a clear source, such as a clear-pending write or an acknowledge strobe. Directed steps drive both in one cycle on purpose: a rising shared line with a clear-pending write, and a software command with an acknowledge of the same ID and CPU. The outcome is judged against R11, and the set must win. The random phase mixes line toggles, writes, commands and acknowledges freely, so many more such collisions occur. Each cycle's outputs are compared with a bench model built from the requirements.

// File: rtl/irqpt_pkg.sv
package irqpt_pkg;
  typedef enum logic [2:0] {
    WK_SET_EN   = 3'd0,
    WK_CLR_EN   = 3'd1,
    WK_SET_PEND = 3'd2,
    WK_CLR_PEND = 3'd3,
    WK_CFG      = 3'd4
  } wr_kind_e;

  typedef enum logic [1:0] {
    SF_LIST   = 2'd0,
    SF_OTHERS = 2'd1,
    SF_SELF   = 2'd2,
    SF_ALL    = 2'd3
  } sgi_filt_e;

  localparam int PRIV_IDS   = 32;
  localparam int FIXED_IDS  = 16;
  localparam int SGI_ID_W   = 10;
endpackage

// File: rtl/irqpt_wr_decode.sv
module irqpt_wr_decode
  import irqpt_pkg::*;
#(
  parameter int NIRQ = 64,
  parameter int GW   = 4
) (
  input  logic            wr_en,
  input  logic [2:0]      wr_kind,
  input  logic [GW-1:0]   wr_grp,
  input  logic [7:0]      wr_data,
  output logic [NIRQ-1:0] set_en,
  output logic [NIRQ-1:0] clr_en,
  output logic [NIRQ-1:0] set_pend,
  output logic [NIRQ-1:0] clr_pend,
  output logic [NIRQ-1:0] cfg_we,
  output logic [NIRQ-1:0] cfg_model,
  output logic [NIRQ-1:0] cfg_edge
);
  localparam int FIX_GRP8 = FIXED_IDS / 8;
  localparam int PRV_GRP4 = PRIV_IDS / 4;

  wr_kind_e   kind;
  logic [7:0] bdat;
  logic [7:0] cdat;

  assign kind = wr_kind_e'(wr_kind);

  // byte data after the fixed-ID overrides
  always_comb begin
    bdat = wr_data;
    if (int'(wr_grp) < FIX_GRP8) begin
      bdat = (kind == WK_SET_EN) ? 8'hFF : 8'h00;
    end
    cdat = wr_data;
    if (int'(wr_grp) < PRV_GRP4) begin
      cdat = wr_data | 8'hAA;
    end
  end

  for (genvar i = 0; i < NIRQ; i++) begin : g_id
    localparam int G8 = i / 8;
    localparam int B8 = i % 8;
    localparam int G4 = i / 4;
    localparam int B4 = i % 4;
    logic hit8;
    logic hit4;
    assign hit8         = wr_en && (int'(wr_grp) == G8) && bdat[B8];
    assign hit4         = wr_en && (int'(wr_grp) == G4);
    assign set_en[i]    = hit8 && (kind == WK_SET_EN);
    assign clr_en[i]    = hit8 && (kind == WK_CLR_EN);
    assign set_pend[i]  = hit8 && (kind == WK_SET_PEND);
    assign clr_pend[i]  = hit8 && (kind == WK_CLR_PEND);
    assign cfg_we[i]    = hit4 && (kind == WK_CFG);
    assign cfg_model[i] = cdat[2*B4];
    assign cfg_edge[i]  = cdat[2*B4+1];
  end
endmodule

// File: rtl/irqpt_sgi_route.sv
module irqpt_sgi_route
  import irqpt_pkg::*;
#(
  parameter int NCPU = 2,
  parameter int NIRQ = 64,
  parameter int CW   = 1
) (
  input  logic                sgi_wr,
  input  logic [CW-1:0]       sgi_cpu,
  input  logic [31:0]         sgi_cmd,
  output logic                sgi_v,
  output logic [SGI_ID_W-1:0] sgi_id,
  output logic [NCPU-1:0]     sgi_mask
);
  logic [NCPU-1:0] self_oh;
  logic            cmd_unused;
  sgi_filt_e       filt;

  assign self_oh    = NCPU'(1) << sgi_cpu;
  assign sgi_id     = sgi_cmd[SGI_ID_W-1:0];
  assign filt       = sgi_filt_e'(sgi_cmd[25:24]);
  assign sgi_v      = sgi_wr && (int'(sgi_id) < NIRQ);
  assign cmd_unused = ^sgi_cmd;

  always_comb begin
    unique case (filt)
      SF_LIST:   sgi_mask = sgi_cmd[16 +: NCPU];
      SF_OTHERS: sgi_mask = ~self_oh;
      SF_SELF:   sgi_mask = self_oh;
      default:   sgi_mask = {NCPU{1'b1}};
    endcase
  end
endmodule

// File: rtl/irqpt_src_cell.sv
module irqpt_src_cell
  import irqpt_pkg::*;
#(
  parameter int NCPU = 2,
  parameter int ID   = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCPU-1:0] lvl_in,
  input  logic [NCPU-1:0] tgt,
  input  logic [NCPU-1:0] req_oh,
  input  logic            set_en,
  input  logic            clr_en,
  input  logic            set_pend,
  input  logic            clr_pend,
  input  logic            cfg_we,
  input  logic            cfg_model,
  input  logic            cfg_edge,
  input  logic [NCPU-1:0] sgi_m,
  input  logic            ack_hit,
  input  logic [NCPU-1:0] ack_oh,
  output logic [NCPU-1:0] pend_q,
  output logic [NCPU-1:0] en_q,
  output logic            edge_q,
  output logic            model_q
);
  localparam bit              PRIV   = (ID < PRIV_IDS);
  localparam logic [NCPU-1:0] ALL    = {NCPU{1'b1}};
  localparam logic [NCPU-1:0] EN_RST = (ID < FIXED_IDS) ? ALL : '0;

  logic [NCPU-1:0] lvl_q;
  logic [NCPU-1:0] rise;
  logic [NCPU-1:0] scope;
  logic [NCPU-1:0] dest;
  logic [NCPU-1:0] pset;
  logic [NCPU-1:0] pclr;
  logic [NCPU-1:0] eset;
  logic [NCPU-1:0] eclr;

  always_comb begin
    rise  = lvl_in & ~lvl_q;
    scope = PRIV ? req_oh : ALL;
    dest  = PRIV ? req_oh : tgt;
    pset  = rise & (PRIV ? ALL : tgt) & (edge_q ? ALL : en_q);
    if (set_en && !edge_q) pset = pset | (dest & lvl_q);
    if (set_pend)          pset = pset | dest;
    pset  = pset | sgi_m;
    pclr  = clr_pend ? ALL : '0;
    if (ack_hit) pclr = pclr | (model_q ? ALL : ack_oh);
    eset  = set_en ? scope : '0;
    eclr  = clr_en ? scope : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q   <= '0;
      pend_q  <= '0;
      en_q    <= EN_RST;
      edge_q  <= PRIV;
      model_q <= 1'b0;
    end else begin
      lvl_q  <= lvl_in;
      pend_q <= (pend_q & ~pclr) | pset;
      en_q   <= (en_q & ~eclr) | eset;
      if (cfg_we) begin
        edge_q  <= cfg_edge;
        model_q <= cfg_model;
      end
    end
  end
endmodule

// File: rtl/irq_pend_tracker.sv
module irq_pend_tracker
  import irqpt_pkg::*;
#(
  parameter int NCPU    = 2,
  parameter int NSHARED = 32,
  localparam int NIRQ   = PRIV_IDS + NSHARED,
  localparam int CW     = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int GW     = $clog2(NIRQ / 4),
  localparam int IDW    = $clog2(NIRQ)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NSHARED-1:0]       shr_lvl_i,
  input  logic [NCPU*PRIV_IDS-1:0] prv_lvl_i,
  input  logic [NSHARED*NCPU-1:0]  tgt_mask_i,
  input  logic                     wr_en_i,
  input  logic [2:0]               wr_kind_i,
  input  logic [CW-1:0]            wr_cpu_i,
  input  logic [GW-1:0]            wr_grp_i,
  input  logic [7:0]               wr_data_i,
  input  logic                     sgi_wr_i,
  input  logic [CW-1:0]            sgi_cpu_i,
  input  logic [31:0]              sgi_cmd_i,
  input  logic                     ack_clr_i,
  input  logic [CW-1:0]            ack_cpu_i,
  input  logic [IDW-1:0]           ack_id_i,
  output logic [NCPU*NIRQ-1:0]     pend_o,
  output logic [NCPU*NIRQ-1:0]     en_o,
  output logic [NIRQ-1:0]          edge_o,
  output logic [NIRQ-1:0]          model_o
);
  logic [NIRQ-1:0]     d_set_en, d_clr_en, d_set_pend, d_clr_pend;
  logic [NIRQ-1:0]     d_cfg_we, d_cfg_model, d_cfg_edge;
  logic                sgi_v;
  logic [SGI_ID_W-1:0] sgi_id;
  logic [NCPU-1:0]     sgi_mask;
  logic [NCPU-1:0]     req_oh;
  logic [NCPU-1:0]     ack_oh;

  assign req_oh = NCPU'(1) << wr_cpu_i;
  assign ack_oh = NCPU'(1) << ack_cpu_i;

  irqpt_wr_decode #(.NIRQ(NIRQ), .GW(GW)) u_dec (
    .wr_en     (wr_en_i),
    .wr_kind   (wr_kind_i),
    .wr_grp    (wr_grp_i),
    .wr_data   (wr_data_i),
    .set_en    (d_set_en),
    .clr_en    (d_clr_en),
    .set_pend  (d_set_pend),
    .clr_pend  (d_clr_pend),
    .cfg_we    (d_cfg_we),
    .cfg_model (d_cfg_model),
    .cfg_edge  (d_cfg_edge)
  );

  irqpt_sgi_route #(.NCPU(NCPU), .NIRQ(NIRQ), .CW(CW)) u_sgi (
    .sgi_wr   (sgi_wr_i),
    .sgi_cpu  (sgi_cpu_i),
    .sgi_cmd  (sgi_cmd_i),
    .sgi_v    (sgi_v),
    .sgi_id   (sgi_id),
    .sgi_mask (sgi_mask)
  );

  for (genvar i = 0; i < NIRQ; i++) begin : g_src
    logic [NCPU-1:0] lvl_in;
    logic [NCPU-1:0] tgt;
    logic [NCPU-1:0] sgi_m;
    logic [NCPU-1:0] pend_q;
    logic [NCPU-1:0] en_q;
    logic            ack_hit;

    if (i < PRIV_IDS) begin : g_prv
      for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        assign lvl_in[c] = prv_lvl_i[c*PRIV_IDS + i];
      end
      assign tgt = '0;
    end else begin : g_shr
      assign lvl_in = {NCPU{shr_lvl_i[i-PRIV_IDS]}};
      assign tgt    = tgt_mask_i[(i-PRIV_IDS)*NCPU +: NCPU];
    end

    assign sgi_m   = (sgi_v && (sgi_id == SGI_ID_W'(i))) ? sgi_mask : '0;
    assign ack_hit = ack_clr_i && (ack_id_i == IDW'(i));

    irqpt_src_cell #(.NCPU(NCPU), .ID(i)) u_cell (
      .clk       (clk),
      .rst       (rst),
      .lvl_in    (lvl_in),
      .tgt       (tgt),
      .req_oh    (req_oh),
      .set_en    (d_set_en[i]),
      .clr_en    (d_clr_en[i]),
      .set_pend  (d_set_pend[i]),
      .clr_pend  (d_clr_pend[i]),
      .cfg_we    (d_cfg_we[i]),
      .cfg_model (d_cfg_model[i]),
      .cfg_edge  (d_cfg_edge[i]),
      .sgi_m     (sgi_m),
      .ack_hit   (ack_hit),
      .ack_oh    (ack_oh),
      .pend_q    (pend_q),
      .en_q      (en_q),
      .edge_q    (edge_o[i]),
      .model_q   (model_o[i])
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_out
      assign pend_o[c*NIRQ + i] = pend_q[c];
      assign en_o[c*NIRQ + i]   = en_q[c];
    end
  end
endmodule

// File: rtl/irqpt_checker.sv
module irqpt_checker
  import irqpt_pkg::*;
#(
  parameter int NCPU    = 2,
  parameter int NSHARED = 32,
  localparam int NIRQ   = PRIV_IDS + NSHARED,
  localparam int CW     = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NSHARED-1:0]   shr_lvl_i,
  input logic                 wr_en_i,
  input logic                 sgi_wr_i,
  input logic [CW-1:0]        sgi_cpu_i,
  input logic [31:0]          sgi_cmd_i,
  input logic                 ack_clr_i,
  input logic [NCPU*NIRQ-1:0] pend_o,
  input logic [NCPU*NIRQ-1:0] en_o,
  input logic [NIRQ-1:0]      edge_o
);
  logic quiet;
  logic self_v;
  int   self_idx;
  logic [NCPU-1:0] shp [NSHARED];

  assign quiet = !wr_en_i && !sgi_wr_i && !ack_clr_i;

  always_comb begin
    for (int n = 0; n < NSHARED; n++) begin
      for (int c = 0; c < NCPU; c++) begin
        shp[n][c] = pend_o[c*NIRQ + PRIV_IDS + n];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      self_v   <= 1'b0;
      self_idx <= 0;
    end else begin
      self_v   <= sgi_wr_i && (sgi_cmd_i[25:24] == 2'd2) &&
                  (int'(sgi_cmd_i[9:0]) < NIRQ);
      self_idx <= int'(sgi_cpu_i) * NIRQ + int'(sgi_cmd_i[9:0]);
    end
  end

  // R1: pending is clear on the first cycle after reset
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pend_o == '0));

  // R9: a self-targeted command always lands on the requester
  a_r9_sgi_self: assert property (@(posedge clk) disable iff (rst)
    self_v |-> pend_o[self_idx]);

  // R6: IDs 0-15 can never lose their enable
  for (genvar c = 0; c < NCPU; c++) begin : g_en
    a_r6_fixed_enabled: assert property (@(posedge clk) disable iff (rst)
      (en_o[c*NIRQ +: FIXED_IDS] == {FIXED_IDS{1'b1}}));
  end

  // R5: private IDs stay edge-triggered
  a_r5_private_edge: assert property (@(posedge clk) disable iff (rst)
    (edge_o[PRIV_IDS-1:0] == {PRIV_IDS{1'b1}}));

  // R3: a falling shared line with no other activity keeps pending
  for (genvar n = 0; n < NSHARED; n++) begin : g_fall
    a_r3_fall_stable: assert property (@(posedge clk) disable iff (rst)
      (quiet && $past(shr_lvl_i[n]) && !shr_lvl_i[n]) |=> $stable(shp[n]));
  end
endmodule

bind irq_pend_tracker irqpt_checker #(.NCPU(NCPU), .NSHARED(NSHARED)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .shr_lvl_i (shr_lvl_i),
  .wr_en_i   (wr_en_i),
  .sgi_wr_i  (sgi_wr_i),
  .sgi_cpu_i (sgi_cpu_i),
  .sgi_cmd_i (sgi_cmd_i),
  .ack_clr_i (ack_clr_i),
  .pend_o    (pend_o),
  .en_o      (en_o),
  .edge_o    (edge_o)
);

// File: tb/sim_irq_pend_tracker.sv
module sim_irq_pend_tracker;
  localparam int CLK_P   = 10;
  localparam int NCPU    = 2;
  localparam int NSHARED = 32;
  localparam int NPRV    = 32;
  localparam int NIRQ    = NPRV + NSHARED;
  localparam int CW      = 1;
  localparam int GW      = 4;
  localparam int IDW     = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NSHARED-1:0]      shr = '0;
  logic [NCPU*NPRV-1:0]    prv = '0;
  logic [NSHARED*NCPU-1:0] tgt = '0;
  logic                    wr_en = 1'b0;
  logic [2:0]              wr_kind = '0;
  logic [CW-1:0]           wr_cpu = '0;
  logic [GW-1:0]           wr_grp = '0;
  logic [7:0]              wr_data = '0;
  logic                    sgi_wr = 1'b0;
  logic [CW-1:0]           sgi_cpu = '0;
  logic [31:0]             sgi_cmd = '0;
  logic                    ack_clr = 1'b0;
  logic [CW-1:0]           ack_cpu = '0;
  logic [IDW-1:0]          ack_id = '0;
  logic [NCPU*NIRQ-1:0]    pend_o, en_o;
  logic [NIRQ-1:0]         edge_o, model_o;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 0;
  string tag   = "R1";

  bit pm [NCPU][NIRQ];
  bit em [NCPU][NIRQ];
  bit ed [NIRQ];
  bit mo [NIRQ];
  bit lp [NCPU][NPRV];
  bit ls [NSHARED];

  always #(CLK_P/2) clk = ~clk;

  irq_pend_tracker #(.NCPU(NCPU), .NSHARED(NSHARED)) u0 (
    .clk(clk), .rst(rst), .shr_lvl_i(shr), .prv_lvl_i(prv), .tgt_mask_i(tgt),
    .wr_en_i(wr_en), .wr_kind_i(wr_kind), .wr_cpu_i(wr_cpu), .wr_grp_i(wr_grp),
    .wr_data_i(wr_data), .sgi_wr_i(sgi_wr), .sgi_cpu_i(sgi_cpu), .sgi_cmd_i(sgi_cmd),
    .ack_clr_i(ack_clr), .ack_cpu_i(ack_cpu), .ack_id_i(ack_id),
    .pend_o(pend_o), .en_o(en_o), .edge_o(edge_o), .model_o(model_o)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic chk(input logic [NCPU*NIRQ-1:0] act, input logic [NCPU*NIRQ-1:0] exp,
                     input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic spot(input logic act, input logic exp, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int i = 0; i < NIRQ; i++) begin
      ed[i] = (i < NPRV);
      mo[i] = 0;
      for (int c = 0; c < NCPU; c++) begin
        pm[c][i] = 0;
        em[c][i] = (i < 16);
      end
    end
    for (int c = 0; c < NCPU; c++) for (int k = 0; k < NPRV; k++) lp[c][k] = 0;
    for (int n = 0; n < NSHARED; n++) ls[n] = 0;
  endfunction

  function automatic bit dst(input int i, input int c, input int req);
    if (i < NPRV) return (c == req);
    return tgt[(i-NPRV)*NCPU + c];
  endfunction

  // next state built from R2-R12
  function automatic void model_step();
    bit ps [NCPU][NIRQ];
    bit pc [NCPU][NIRQ];
    bit es [NCPU][NIRQ];
    bit ec [NCPU][NIRQ];
    logic [7:0] d;
    int g;
    int req;
    for (int i = 0; i < NIRQ; i++)
      for (int c = 0; c < NCPU; c++) begin
        bit inb, st;
        ps[c][i] = 0; pc[c][i] = 0; es[c][i] = 0; ec[c][i] = 0;
        inb = (i < NPRV) ? prv[c*NPRV+i] : shr[i-NPRV];
        st  = (i < NPRV) ? lp[c][i] : ls[i-NPRV];
        if (inb && !st && dst(i, c, c) && (ed[i] || em[c][i])) ps[c][i] = 1;
      end
    g = int'(wr_grp);
    req = int'(wr_cpu);
    if (wr_en && wr_kind <= 3 && g < NIRQ/8) begin
      d = wr_data;
      if (g < 2) d = (wr_kind == 0) ? 8'hFF : 8'h00;
      for (int b = 0; b < 8; b++) if (d[b]) begin
        int i;
        i = g*8 + b;
        for (int c = 0; c < NCPU; c++) begin
          bit inscope;
          bit st;
          inscope = (i < NPRV) ? (c == req) : 1'b1;
          st = (i < NPRV) ? lp[c][i] : ls[i-NPRV];
          case (wr_kind)
            3'd0: begin
              if (inscope) es[c][i] = 1;
              if (!ed[i] && dst(i, c, req) && st) ps[c][i] = 1;
            end
            3'd1: if (inscope) ec[c][i] = 1;
            3'd2: if (dst(i, c, req)) ps[c][i] = 1;
            default: pc[c][i] = 1;
          endcase
        end
      end
    end
    if (sgi_wr && int'(sgi_cmd[9:0]) < NIRQ) begin
      int id;
      id = int'(sgi_cmd[9:0]);
      for (int c = 0; c < NCPU; c++) begin
        bit hit;
        case (sgi_cmd[25:24])
          2'd0: hit = sgi_cmd[16+c];
          2'd1: hit = (c != int'(sgi_cpu));
          2'd2: hit = (c == int'(sgi_cpu));
          default: hit = 1;
        endcase
        if (hit) ps[c][id] = 1;
      end
    end
    if (ack_clr && int'(ack_id) < NIRQ) begin
      for (int c = 0; c < NCPU; c++)
        if (mo[ack_id] || c == int'(ack_cpu)) pc[c][ack_id] = 1;
    end
    for (int i = 0; i < NIRQ; i++)
      for (int c = 0; c < NCPU; c++) begin
        pm[c][i] = (pm[c][i] && !pc[c][i]) || ps[c][i];
        em[c][i] = (em[c][i] && !ec[c][i]) || es[c][i];
      end
    if (wr_en && wr_kind == 3'd4 && g < NIRQ/4) begin
      d = wr_data;
      if (g < 8) d = d | 8'hAA;
      for (int k = 0; k < 4; k++) begin
        mo[g*4+k] = d[2*k];
        ed[g*4+k] = d[2*k+1];
      end
    end
    for (int c = 0; c < NCPU; c++) for (int k = 0; k < NPRV; k++) lp[c][k] = prv[c*NPRV+k];
    for (int n = 0; n < NSHARED; n++) ls[n] = shr[n];
  endfunction

  task automatic compare_all();
    logic [NCPU*NIRQ-1:0] xp, xe;
    logic [NIRQ-1:0] xd, xm;
    for (int i = 0; i < NIRQ; i++) begin
      xd[i] = ed[i];
      xm[i] = mo[i];
      for (int c = 0; c < NCPU; c++) begin
        xp[c*NIRQ+i] = pm[c][i];
        xe[c*NIRQ+i] = em[c][i];
      end
    end
    chk(pend_o, xp, "pending");
    chk(en_o, xe, "enable");
    chk({{(NCPU*NIRQ-NIRQ){1'b0}}, edge_o}, {{(NCPU*NIRQ-NIRQ){1'b0}}, xd}, "trigger");
    chk({{(NCPU*NIRQ-NIRQ){1'b0}}, model_o}, {{(NCPU*NIRQ-NIRQ){1'b0}}, xm}, "model");
  endtask

  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    wr_en = 0; sgi_wr = 0; ack_clr = 0;
  endtask

  task automatic wr(input int kind, input int cpu, input int grp, input int data);
    wr_en = 1; wr_kind = 3'(kind); wr_cpu = CW'(cpu); wr_grp = GW'(grp); wr_data = 8'(data);
  endtask

  task automatic sgi(input int cpu, input int id, input int filt, input int lst);
    sgi_wr = 1; sgi_cpu = CW'(cpu);
    sgi_cmd = (32'(filt) << 24) | (32'(lst) << 16) | 32'(id);
  endtask

  task automatic ack(input int cpu, input int id);
    ack_clr = 1; ack_cpu = CW'(cpu); ack_id = IDW'(id);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    tag = "R1";
    compare_all();
    spot(en_o[15], 1'b1, "id15 enabled");
    spot(en_o[16], 1'b0, "id16 disabled");
    spot(edge_o[31], 1'b1, "id31 edge");
    spot(edge_o[32], 1'b0, "id32 level");

    tag = "R5";
    wr(4, 0, 8, 8'h06); step();
    spot(edge_o[32], 1'b1, "id32 edge");
    spot(model_o[33], 1'b1, "id33 model");
    spot(edge_o[33], 1'b0, "id33 level");
    wr(4, 0, 0, 8'h00); step();
    spot(edge_o[2], 1'b1, "id2 forced edge");

    tag = "R2";
    tgt[1] = 1; tgt[4] = 1; tgt[5] = 1; tgt[16] = 1;
    shr[0] = 1; step();
    spot(pend_o[NIRQ+32], 1'b1, "id32 cpu1");
    spot(pend_o[32], 1'b0, "id32 cpu0 untargeted");
    shr[2] = 1; step();
    spot(pend_o[34], 1'b0, "level id34 disabled");

    tag = "R3";
    step();
    shr[0] = 0; step();
    spot(pend_o[NIRQ+32], 1'b1, "id32 held after fall");

    tag = "R4";
    wr(0, 0, 4, 8'h04); step();
    spot(pend_o[34], 1'b1, "id34 cpu0");
    spot(pend_o[NIRQ+34], 1'b1, "id34 cpu1");

    tag = "R7";
    wr(0, 1, 2, 8'h10); step();
    spot(en_o[NIRQ+20], 1'b1, "id20 cpu1 bank");
    spot(en_o[20], 1'b0, "id20 cpu0 bank");
    wr(5, 0, 3, 8'hFF); step();

    tag = "R6";
    wr(1, 0, 0, 8'hFF); step();
    spot(en_o[3], 1'b1, "id3 clear ignored");
    wr(2, 0, 1, 8'hFF); step();
    spot(pend_o[8], 1'b0, "id8 set ignored");

    tag = "R8";
    wr(2, 0, 5, 8'h01); step();
    spot(pend_o[40], 1'b1, "id40 cpu0");
    spot(pend_o[NIRQ+40], 1'b0, "id40 cpu1");
    wr(3, 0, 4, 8'h01); step();
    spot(pend_o[NIRQ+32], 1'b0, "id32 cleared");

    tag = "R9";
    sgi(0, 5, 1, 0); step();
    spot(pend_o[NIRQ+5], 1'b1, "others cpu1");
    spot(pend_o[5], 1'b0, "others cpu0");
    sgi(1, 6, 0, 1); step();
    spot(pend_o[6], 1'b1, "list cpu0");
    sgi(1, 7, 2, 0); step();
    spot(pend_o[NIRQ+7], 1'b1, "self cpu1");
    sgi(0, 9, 3, 0); step();
    spot(pend_o[9], 1'b1, "all cpu0");
    sgi(0, 100, 3, 0); step();

    tag = "R10";
    ack(1, 9); step();
    spot(pend_o[NIRQ+9], 1'b0, "ack cpu1");
    spot(pend_o[9], 1'b1, "model0 keeps cpu0");
    wr(4, 0, 2, 8'h04); step();
    sgi(0, 9, 3, 0); step();
    ack(0, 9); step();
    spot(pend_o[NIRQ+9], 1'b0, "model1 clears cpu1");

    tag = "R11";
    sgi(0, 12, 2, 0); ack(0, 12); step();
    spot(pend_o[12], 1'b1, "sgi beats ack");
    shr[0] = 1; wr(3, 0, 4, 8'h01); step();
    spot(pend_o[NIRQ+32], 1'b1, "rise beats clear");

    tag = "R12";
    prv[NPRV+3] = 1; step();
    spot(pend_o[NIRQ+3], 1'b1, "private line cpu1 id3");
    spot(pend_o[3], 1'b0, "private line cpu0 id3");

    tag = "R11";
    for (int t = 0; t < 3000; t++) begin
      shr = shr ^ ($urandom & $urandom & $urandom);
      prv = prv ^ {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom};
      if ($urandom % 16 == 0) tgt = {$urandom, $urandom};
      if ($urandom % 10 < 4) wr($urandom % 6, $urandom % NCPU, $urandom % 16, $urandom);
      if ($urandom % 7 == 0) sgi($urandom % NCPU, $urandom % 72, $urandom % 4, $urandom % 4);
      if ($urandom % 5 == 0) ack($urandom % NCPU, $urandom % NIRQ);
      step();
    end

    done = 1;
    summary();
    $finish;
  end
endmodule